// File: doc/BRIEF.md
# Counter Machine Instruction Core

This block is a very small register-machine processor. It has four counter registers and runs programs built from only five primitive instructions: clear, increment, decrement-or-branch-if-zero, unconditional jump and halt. There is no adder, no shifter and no data memory. Doubling, halving, copying and remainder are all written as loops over these primitives.

A program is written into a 256-word instruction store through a valid/ready load port while the core is idle. A one-cycle `start` pulse then begins execution at address 0. The core fetches and executes exactly one instruction per clock. When it meets a halt it freezes all state and raises `halted` until the next reset. A debug view shows the program counter and all four registers at all times.

The load port uses back-pressure. `ld_ready` is high only while the core is idle, which is after reset and before `start`. A word is stored on a clock edge where both `ld_valid` and `ld_ready` are high. Any word offered while `ld_ready` is low is not stored and is not queued, so the producer must keep it and offer it again.

Top module: `cm_core`

## Requirements
- R1: While reset is asserted (rst_n low), and on the first edge after it, all registers read 0, `dbg_pc` is 0, `halted`, `running` and `ovf` are 0 and `ld_ready` is 1. Reset also fills the instruction store with the all-zero word, which is a halt.
- R2: The instruction word is {opcode[12:10], reg[9:8], target[7:0]}, and reg index 0..3 selects registers A, B, C, D. A word is written to `ld_addr` on an edge with `ld_valid` and `ld_ready` both high. `ld_ready` is high only while the core is idle.
- R3: A `start` pulse sampled while idle sets `running` on that edge with `dbg_pc` = 0. Each following edge executes one instruction.
- R4: Opcode 1 (clear) writes 0 to the selected register and advances the PC by one.
- R5: Opcode 2 (increment) adds one to the selected register and advances the PC. Incrementing the all-ones value gives 0 and sets `ovf`, which stays set until reset.
- R6: Opcode 3 (decrement-jump) loads the PC with the target and leaves the register unchanged when the register is 0. Otherwise it subtracts one from the register and advances the PC.
- R7: Opcode 4 (jump) loads the PC with the target and changes no register.
- R8: Opcode 0, and the reserved opcodes 5 to 7, halt the core. `halted` goes high on that edge, `dbg_pc` stays on the halting address, and every register, the PC and `halted` hold until reset.
- R9: The program that sets C to 3, clears B and then loops on decrement-jump of C, incrementing B twice per pass, halts with B = 6 and C = 0 after 19 executed instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Load word offered |
| ld_ready | output | 1 | Load word accepted (core idle) |
| ld_addr | input | AW (8) | Instruction store address for the load |
| ld_word | input | 3+2+AW (13) | Instruction word to store |
| start | input | 1 | Begin execution at address 0 (idle only) |
| running | output | 1 | Core is executing |
| halted | output | 1 | Core has stopped; held until reset |
| ovf | output | 1 | Sticky increment wrap flag |
| dbg_pc | output | AW (8) | Current program counter |
| dbg_regs | output | 4*RW (64) | Registers A..D, A in the low RW bits |

## Verification
`halted` rises exactly N edges after the edge that sampled `start`, where N is the number of instructions the program executes, counting the halt itself. `ld_ready` falls on the start edge. The bench counts rising edges from the start edge onward and samples 1 ns after each one. It records the edge count at which `halted` first appears and compares it with the N worked out by hand for each program. The final PC, registers and `ovf` are checked at that same edge. They are checked again four edges later to confirm the state is frozen.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int OP_W   = 3;
  localparam int RIDX_W = 2;
  localparam int NREG   = 1 << RIDX_W;

  localparam logic [OP_W-1:0] OP_HALT = 3'd0;
  localparam logic [OP_W-1:0] OP_CLR  = 3'd1;
  localparam logic [OP_W-1:0] OP_INC  = 3'd2;
  localparam logic [OP_W-1:0] OP_DJZ  = 3'd3;
  localparam logic [OP_W-1:0] OP_JMP  = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_STOP = 2'd2
  } cm_state_e;
endpackage

// File: rtl/cm_progmem.sv
module cm_progmem #(
  parameter int AW = 8,
  parameter int IW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [IW-1:0] wr_word,
  input  logic [AW-1:0] rd_addr,
  output logic [IW-1:0] rd_word
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_word;
    end
  end

  assign rd_word = mem[rd_addr];
endmodule

// File: rtl/cm_regfile.sv
module cm_regfile
  import cm_pkg::*;
#(
  parameter int RW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RIDX_W-1:0] sel,
  input  logic              do_clr,
  input  logic              do_inc,
  input  logic              do_dec,
  output logic              sel_zero,
  output logic              ovf,
  output logic [NREG*RW-1:0] regs_flat
);
  logic [RW-1:0] r [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r[g] <= '0;
      end else if (sel == RIDX_W'(g)) begin
        if (do_clr)      r[g] <= '0;
        else if (do_inc) r[g] <= r[g] + 1'b1;
        else if (do_dec) r[g] <= r[g] - 1'b1;
      end
    end
    assign regs_flat[g*RW +: RW] = r[g];
  end

  assign sel_zero = (r[sel] == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                        ovf <= 1'b0;
    else if (do_inc && (&r[sel]))      ovf <= 1'b1;
  end
endmodule

// File: rtl/cm_seq.sv
module cm_seq
  import cm_pkg::*;
#(
  parameter int AW = 8,
  parameter int IW = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IW-1:0]     instr,
  input  logic              sel_zero,
  output logic [AW-1:0]     pc,
  output logic [RIDX_W-1:0] sel,
  output logic              do_clr,
  output logic              do_inc,
  output logic              do_dec,
  output logic              idle,
  output logic              running,
  output logic              halted
);
  cm_state_e        state, state_nx;
  logic [AW-1:0]    pc_nx;
  logic [OP_W-1:0]  opc;
  logic [AW-1:0]    tgt;

  assign opc = instr[IW-1 -: OP_W];
  assign sel = instr[AW +: RIDX_W];
  assign tgt = instr[AW-1:0];

  always_comb begin
    state_nx = state;
    pc_nx    = pc;
    do_clr   = 1'b0;
    do_inc   = 1'b0;
    do_dec   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          state_nx = ST_RUN;
          pc_nx    = '0;
        end
      end
      ST_RUN: begin
        case (opc)
          OP_CLR: begin
            do_clr = 1'b1;
            pc_nx  = pc + 1'b1;
          end
          OP_INC: begin
            do_inc = 1'b1;
            pc_nx  = pc + 1'b1;
          end
          OP_DJZ: begin
            if (sel_zero) begin
              pc_nx = tgt;
            end else begin
              do_dec = 1'b1;
              pc_nx  = pc + 1'b1;
            end
          end
          OP_JMP:  pc_nx = tgt;
          default: state_nx = ST_STOP;
        endcase
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pc    <= '0;
    end else begin
      state <= state_nx;
      pc    <= pc_nx;
    end
  end

  assign idle    = (state == ST_IDLE);
  assign running = (state == ST_RUN);
  assign halted  = (state == ST_STOP);
endmodule

// File: rtl/cm_core.sv
module cm_core
  import cm_pkg::*;
#(
  parameter int AW = 8,
  parameter int RW = 16,
  localparam int IW = OP_W + RIDX_W + AW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_valid,
  output logic               ld_ready,
  input  logic [AW-1:0]      ld_addr,
  input  logic [IW-1:0]      ld_word,
  input  logic               start,
  output logic               running,
  output logic               halted,
  output logic               ovf,
  output logic [AW-1:0]      dbg_pc,
  output logic [NREG*RW-1:0] dbg_regs
);
  logic [IW-1:0]     instr;
  logic [AW-1:0]     pc;
  logic [RIDX_W-1:0] sel;
  logic              do_clr, do_inc, do_dec, sel_zero, idle;

  cm_progmem #(.AW(AW), .IW(IW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ld_valid && idle),
    .wr_addr (ld_addr),
    .wr_word (ld_word),
    .rd_addr (pc),
    .rd_word (instr)
  );

  cm_seq #(.AW(AW), .IW(IW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .instr    (instr),
    .sel_zero (sel_zero),
    .pc       (pc),
    .sel      (sel),
    .do_clr   (do_clr),
    .do_inc   (do_inc),
    .do_dec   (do_dec),
    .idle     (idle),
    .running  (running),
    .halted   (halted)
  );

  cm_regfile #(.RW(RW)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .do_clr    (do_clr),
    .do_inc    (do_inc),
    .do_dec    (do_dec),
    .sel_zero  (sel_zero),
    .ovf       (ovf),
    .regs_flat (dbg_regs)
  );

  assign ld_ready = idle;
  assign dbg_pc   = pc;
endmodule

// File: rtl/cm_core_chk.sv
module cm_core_chk #(
  parameter int AW = 8,
  parameter int RW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ld_ready,
  input logic            start,
  input logic            running,
  input logic            halted,
  input logic            ovf,
  input logic [AW-1:0]   dbg_pc,
  input logic [4*RW-1:0] dbg_regs
);
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ready |-> (!running && !halted)); // R2

  AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_ready && start) |=> (running && dbg_pc == '0)); // R3

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R5

  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted); // R8

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> ($stable(dbg_pc) && $stable(dbg_regs) && $stable(ovf))); // R8

  AST_STATE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_ready, running, halted})); // R8
endmodule

bind cm_core cm_core_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ld_ready (ld_ready),
  .start    (start),
  .running  (running),
  .halted   (halted),
  .ovf      (ovf),
  .dbg_pc   (dbg_pc),
  .dbg_regs (dbg_regs)
);

// File: tb/cm_core_bench.sv
module cm_core_bench;
  localparam int AW = 8;
  localparam int RW = 8;
  localparam int IW = 13;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            ld_valid = 1'b0;
  logic            ld_ready;
  logic [AW-1:0]   ld_addr = '0;
  logic [IW-1:0]   ld_word = '0;
  logic            start = 1'b0;
  logic            running, halted, ovf;
  logic [AW-1:0]   dbg_pc;
  logic [4*RW-1:0] dbg_regs;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  cm_core #(.AW(AW), .RW(RW)) u_cm_core (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_word(ld_word), .start(start), .running(running),
    .halted(halted), .ovf(ovf), .dbg_pc(dbg_pc), .dbg_regs(dbg_regs)
  );

  typedef struct {
    string name;
    int    cycles;
    int    pc;
    int    ra, rb, rc, rd;
    bit    ovf;
  } exp_t;

  exp_t exp_q[$];
  bit   armed = 1'b0;
  bit   done  = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int rg(input int i);
    return int'(dbg_regs[i*RW +: RW]);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // opcode: 0 halt, 1 clear, 2 increment, 3 decrement-jump, 4 jump
  task automatic put(input int addr, input int op, input int r, input int tgt);
    @(negedge clk);
    ld_valid = 1'b1;
    ld_addr  = AW'(addr);
    ld_word  = {3'(op), 2'(r), 8'(tgt)};
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic run_prog(input exp_t e);
    exp_q.push_back(e);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1;
    start = 1'b0;
    done  = 1'b0;
    armed = 1'b1;
    wait (done);
  endtask

  // monitor: counts edges after the start edge, samples 1 ns after each
  initial begin
    forever begin
      exp_t e;
      int   n;
      wait (armed);
      e = exp_q.pop_front();
      n = 0;
      forever begin
        @(posedge clk);
        #1;
        n++;
        if (n == 1) begin
          chk(ld_ready == 1'b0, "R2", {e.name, " ld_ready while running"}, int'(ld_ready), 0);
          chk(running || halted, "R3", {e.name, " running after start"}, int'(running), 1);
        end
        if (halted || n > 5000) break;
      end
      chk(n == e.cycles, "R3", {e.name, " edges to halt"}, n, e.cycles);
      chk(int'(dbg_pc) == e.pc, "R8", {e.name, " halt pc"}, int'(dbg_pc), e.pc);
      chk(rg(0) == e.ra, "R4", {e.name, " reg A"}, rg(0), e.ra);
      chk(rg(1) == e.rb, "R9", {e.name, " reg B"}, rg(1), e.rb);
      chk(rg(2) == e.rc, "R6", {e.name, " reg C"}, rg(2), e.rc);
      chk(rg(3) == e.rd, "R5", {e.name, " reg D"}, rg(3), e.rd);
      chk(ovf == e.ovf, "R5", {e.name, " ovf"}, int'(ovf), int'(e.ovf));
      repeat (4) @(posedge clk);
      #1;
      chk(halted == 1'b1, "R8", {e.name, " halted held"}, int'(halted), 1);
      chk(int'(dbg_pc) == e.pc, "R8", {e.name, " pc frozen"}, int'(dbg_pc), e.pc);
      chk(rg(1) == e.rb && rg(3) == e.rd, "R8", {e.name, " regs frozen"},
          rg(1) + rg(3), e.rb + e.rd);
      armed = 1'b0;
      done  = 1'b1;
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    exp_t e;
    @(negedge clk);
    #1;
    chk(dbg_pc == '0 && dbg_regs == '0, "R1", "regs and pc in reset", int'(dbg_pc), 0);
    chk(!halted && !running && !ovf, "R1", "flags in reset", int'(halted), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ld_ready == 1'b1, "R1", "ld_ready after reset", int'(ld_ready), 1);

    // R1/R8: cleared store halts at address 0 in one instruction
    e = '{"empty", 1, 0, 0, 0, 0, 0, 1'b0};
    run_prog(e);

    // R9: C=3, B+=2 per pass
    do_reset();
    put(0, 1, 2, 0); put(1, 2, 2, 0); put(2, 2, 2, 0); put(3, 2, 2, 0);
    put(4, 1, 1, 0); put(5, 3, 2, 9); put(6, 2, 1, 0); put(7, 2, 1, 0);
    put(8, 4, 0, 5);
    e = '{"double3", 19, 9, 0, 6, 0, 0, 1'b0};
    run_prog(e);

    // R6: halve C=5 into A, remainder in B
    do_reset();
    put(0, 1, 2, 0);
    for (int i = 1; i <= 5; i++) put(i, 2, 2, 0);
    put(6, 1, 0, 0); put(7, 1, 1, 0); put(8, 3, 2, 13); put(9, 2, 1, 0);
    put(10, 3, 2, 13); put(11, 2, 0, 0); put(12, 4, 0, 7);
    e = '{"halve5", 24, 13, 2, 1, 0, 0, 1'b0};
    run_prog(e);

    // R4/R7: clear after increments, jump skips an increment of C
    do_reset();
    put(0, 2, 0, 0); put(1, 2, 0, 0); put(2, 1, 0, 0); put(3, 2, 1, 0);
    put(4, 4, 0, 6); put(5, 2, 2, 0);
    e = '{"clrjmp", 6, 6, 0, 1, 0, 0, 1'b0};
    run_prog(e);

    // R8: reserved opcode 6 halts
    do_reset();
    put(0, 2, 3, 0); put(1, 6, 0, 0);
    e = '{"reserved", 2, 1, 0, 0, 0, 1, 1'b0};
    run_prog(e);

    // R5: D counts up until it wraps (RW=8 -> 256 passes)
    do_reset();
    put(0, 1, 3, 0); put(1, 2, 3, 0); put(2, 3, 3, 5); put(3, 2, 3, 0);
    put(4, 4, 0, 1);
    e = '{"wrap", 1024, 5, 0, 0, 0, 0, 1'b1};
    run_prog(e);

    // R1: reset clears ovf and halted
    do_reset();
    @(negedge clk);
    chk(!ovf && !halted && ld_ready, "R1", "flags cleared by reset", int'(ovf), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule